// File: doc/BRIEF.md
# Instruction-Cycle Control Sequencer

This block is the hardwired controller that paces a small processor through its instruction cycle. It holds a two-bit state that moves through a fetch step. From fetch it goes either to a decode step or, when an interrupt request is present, to a trap step. Decode leads to an execute step. Execute and trap both return to fetch. In every cycle the block raises exactly one strobe, so the datapath knows which step is under way.

The next-state and strobe logic is built the way a programmable logic array is built. An AND plane forms five product terms from the interrupt level and the two state bits. Inputs that a row does not care about are masked out of that row's term. An OR plane then combines these terms into each next-state bit and each strobe. Both planes are generated from constant row tables, so changing the control behaviour means editing a table and not restructuring logic.

Top module: `ctl_seq_fsm`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the state becomes fetch (code 0) at that edge. After reset the fetch strobe (bit 0) is the only strobe high.
- R2: In fetch (code 0) with `irq_i` high at the edge, the next state is trap (code 2).
- R3: In fetch (code 0) with `irq_i` low at the edge, the next state is decode (code 1).
- R4: Decode (code 1) always moves to execute (code 3), whatever the level of `irq_i`.
- R5: Execute (code 3) always returns to fetch (code 0), whatever the level of `irq_i`.
- R6: Trap (code 2) always returns to fetch (code 0), whatever the level of `irq_i`.
- R7: `strobe_o` is one-hot in every cycle after reset. The bit at the index equal to the state code is the high bit: bit 0 fetch, bit 1 decode, bit 2 trap, bit 3 execute.
- R8: `irq_i` is sampled only on the edge that leaves fetch. A request that is raised and dropped during decode, execute or trap leaves no trace, and the following fetch with `irq_i` low goes to decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_i | input | 1 | Interrupt request level |
| state_o | output | 2 | Current state code (0 fetch, 1 decode, 2 trap, 3 execute) |
| strobe_o | output | 4 | One-hot step strobes, indexed by state code |

## Verification
The hardest condition to reach is an interrupt level that changes in the exact cycle the controller sits in fetch. It must be told apart from requests that come and go while the controller is elsewhere, which must be ignored. Random requests with different densities run against a behavioural next-state model, with occasional mid-run resets, so fetch sees both levels many times. Directed sequences pulse the request only during decode, execute and trap. They then drop it at fetch, or hold it high through a whole trap round trip.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    localparam int unsigned STATE_W  = 2;
    localparam int unsigned STROBE_N = 1 << STATE_W;
    localparam int unsigned IN_W     = STATE_W + 1;      // {irq, state}
    localparam int unsigned TERM_N   = 5;
    localparam int unsigned OUT_N    = STROBE_N + STATE_W; // strobes, then next bits

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_TRAP   = 2'd2,
        ST_EXEC   = 2'd3
    } ctl_state_e;

    // One AND-plane row: bits set in care take part, match gives their value.
    typedef struct packed {
        logic [IN_W-1:0] care;
        logic [IN_W-1:0] match;
    } term_row_t;

    typedef struct packed {
        ctl_state_e st;
    } ctl_regs_t;

    // Input vector layout: bit 2 = irq, bits 1:0 = current state code.
    function automatic term_row_t term_row(input int idx);
        term_row_t r;
        case (idx)
            0: begin r.care = 3'b111; r.match = 3'b000; end // fetch, no request
            1: begin r.care = 3'b111; r.match = 3'b100; end // fetch, request
            2: begin r.care = 3'b011; r.match = 3'b001; end // decode
            3: begin r.care = 3'b011; r.match = 3'b010; end // trap
            4: begin r.care = 3'b011; r.match = 3'b011; end // execute
            default: begin r.care = '0; r.match = '1; end
        endcase
        return r;
    endfunction

    // OR-plane column: which terms feed output idx.
    // idx 0..3 are strobes by state code; idx 4 / 5 are next-state bit 0 / 1.
    function automatic logic [TERM_N-1:0] or_column(input int idx);
        logic [TERM_N-1:0] c;
        case (idx)
            0:       c = 5'b00011; // fetch strobe
            1:       c = 5'b00100; // decode strobe
            2:       c = 5'b01000; // trap strobe
            3:       c = 5'b10000; // execute strobe
            4:       c = 5'b00101; // next bit 0
            5:       c = 5'b00110; // next bit 1
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctl_and_plane.sv
module ctl_and_plane
    import ctl_seq_pkg::*;
#(
    parameter int unsigned IN_BITS = IN_W,
    parameter int unsigned TERMS   = TERM_N
) (
    input  logic [IN_BITS-1:0] in_i,
    output logic [TERMS-1:0]   term_o
);

    for (genvar g = 0; g < TERMS; g++) begin : g_term
        localparam term_row_t ROW = term_row(g);
        // A term fires when every cared-about input equals its row value.
        assign term_o[g] = (((in_i ^ ROW.match[IN_BITS-1:0]) & ROW.care[IN_BITS-1:0]) == '0);
    end

endmodule

// File: rtl/ctl_or_plane.sv
module ctl_or_plane
    import ctl_seq_pkg::*;
#(
    parameter int unsigned TERMS = TERM_N,
    parameter int unsigned OUTS  = OUT_N
) (
    input  logic [TERMS-1:0] term_i,
    output logic [OUTS-1:0]  out_o
);

    for (genvar g = 0; g < OUTS; g++) begin : g_col
        localparam logic [TERM_N-1:0] COL = or_column(g);
        assign out_o[g] = |(term_i & COL[TERMS-1:0]);
    end

endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
    import ctl_seq_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                irq_i,
    output logic [STATE_W-1:0]  state_o,
    output logic [STROBE_N-1:0] strobe_o
);

    ctl_regs_t           regs_d;
    ctl_regs_t           regs_q;
    logic [IN_W-1:0]     plane_in;
    logic [TERM_N-1:0]   terms;
    logic [OUT_N-1:0]    plane_out;

    assign plane_in = {irq_i, regs_q.st};

    ctl_and_plane #(
        .IN_BITS (IN_W),
        .TERMS   (TERM_N)
    ) u_and (
        .in_i   (plane_in),
        .term_o (terms)
    );

    ctl_or_plane #(
        .TERMS (TERM_N),
        .OUTS  (OUT_N)
    ) u_or (
        .term_i (terms),
        .out_o  (plane_out)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = ctl_state_e'(plane_out[OUT_N-1:STROBE_N]);
        if (rst_i) begin
            regs_d.st = ST_FETCH;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign state_o  = regs_q.st;
    assign strobe_o = plane_out[STROBE_N-1:0];

endmodule

// File: rtl/ctl_seq_fsm_chk.sv
module ctl_seq_fsm_chk
    import ctl_seq_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                irq_i,
    input logic [STATE_W-1:0]  state_o,
    input logic [STROBE_N-1:0] strobe_o
);

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 2'd0));

    // R2
    fetch_irq_trap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd0 && irq_i) |=> (state_o == 2'd2));

    // R3
    fetch_noirq_decode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd0 && !irq_i) |=> (state_o == 2'd1));

    // R4
    decode_to_exec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd1) |=> (state_o == 2'd3));

    // R5
    exec_to_fetch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd3) |=> (state_o == 2'd0));

    // R6
    trap_to_fetch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd2) |=> (state_o == 2'd0));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(strobe_o) && strobe_o[state_o]);

endmodule

bind ctl_seq_fsm ctl_seq_fsm_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .irq_i    (irq_i),
    .state_o  (state_o),
    .strobe_o (strobe_o)
);

// File: tb/ctl_seq_fsm_tb.sv
module ctl_seq_fsm_tb;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       irq_i = 1'b0;
    logic [1:0] state_o;
    logic [3:0] strobe_o;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    logic [1:0]  exp_st = 2'd0;
    bit          done   = 1'b0;

    always #2 clk_i = ~clk_i; // 250 MHz

    ctl_seq_fsm u_dut (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .irq_i    (irq_i),
        .state_o  (state_o),
        .strobe_o (strobe_o)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic irq);
        case (s)
            2'd0:    return irq ? 2'd2 : 2'd1;
            2'd1:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] s, input logic irq, input logic rst);
        if (rst) return "R1";
        case (s)
            2'd0:    return irq ? "R2" : "R3";
            2'd1:    return "R4";
            2'd3:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_state(input string req, input logic [1:0] exp);
        n_run++;
        if (state_o !== exp) begin
            n_fail++;
            $display("FAIL %s state got %0d expected %0d", req, state_o, exp);
        end
    endtask

    task automatic check_strobe(input logic [1:0] s);
        logic [3:0] exp;
        exp = 4'b0001 << s;
        n_run++;
        if (strobe_o !== exp) begin
            n_fail++;
            $display("FAIL R7 strobe got %b expected %b", strobe_o, exp);
        end
    endtask

    // Drive inputs after an edge, advance one edge, sample 1 ns later.
    task automatic step(input logic rst, input logic irq, input string tag);
        string req;
        rst_i = rst;
        irq_i = irq;
        req   = (tag != "") ? tag : req_of(exp_st, irq, rst);
        @(posedge clk_i);
        exp_st = rst ? 2'd0 : ref_next(exp_st, irq);
        #1;
        check_state(req, exp_st);
        check_strobe(exp_st);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R1");

        // R3, R4, R5: plain cycle with no request
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R5");

        // R2, R6: request at fetch, held high through trap
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R6");

        // R8: pulses only outside fetch, then low at fetch -> decode
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, "R8");

        // R1: reset taken from the middle of a cycle
        step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, "R1");

        // Random phases with different request densities
        for (int phase = 0; phase < 3; phase++) begin
            for (int i = 0; i < 1500; i++) begin
                logic irq;
                logic rst;
                case (phase)
                    0:       irq = ($urandom % 4) == 0;
                    1:       irq = ($urandom % 2) == 0;
                    default: irq = ($urandom % 8) != 0;
                endcase
                rst = ($urandom % 101) == 0;
                step(rst, irq, "");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule